// File: doc/BRIEF.md
# I2C Master Command Engine

This block is the bus-side core of a register-driven I2C master. Software writes a small control register to launch one bus condition at a time: a START, a repeated START or a STOP. It hands over single bytes through a valid/ready port. Each byte is shifted onto SDA most significant bit first. A ninth clock follows, in which the slave's acknowledge is sampled. The outcome of that acknowledge is returned in the same control register that carries the command.

Both bus lines are driven as active-low open-drain enables and are read back through separate inputs. All bus timing is taken from an external tick that arrives four times per bit period. Each tick advances the engine by one quarter-bit step. A slave that holds SCL low stalls the engine at the step where SCL should be high.

While an operation runs, a busy flag is high and the engine takes no new work. When the operation ends, a sticky session-done flag is raised. After each operation, software writes the command field back to no-action.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, both line enables are released (high), `cmd_busy`, `sess_done` and `byte_ready` are low, and `ctl_rdata` reads 0.
- R2: The control register layout is as follows. Bit 0 is enable and bits 2:1 are the command. Bit 3 selects a repeated START when written and reads back as the latched acknowledge result. Bits 2:0 read back as last written.
- R3: Command code 1 with bit 3 = 0 makes a plain START from the idle bus: SDA falls while SCL is high, then SCL is pulled low. The operation consumes 2 ticks.
- R4: Command code 1 with bit 3 = 1 makes a repeated START in 4 ticks. SDA is released first, then SCL is released, then SDA falls while SCL is high, then SCL is pulled low.
- R5: Command code 2 makes a STOP in 3 ticks: SDA is pulled low, SCL is released, then SDA rises while SCL is high. Afterwards both lines stay released.
- R6: A byte accepted on the data port is sent MSB first in 8 bit periods, followed by one acknowledge period, for 36 ticks in total. During a byte, SDA changes only while SCL is low.
- R7: SDA sampled high in the acknowledge period (NAK) makes bit 3 of `ctl_rdata` read 1. SDA sampled low (ACK) makes it read 0.
- R8: `cmd_busy` is high from the cycle after a launch until the operation completes. While it is high, `byte_ready` is low and control writes are ignored.
- R9: `sess_done` is set when each command or byte completes and is cleared by `done_clr`. When both happen in the same cycle, the set wins.
- R10: With the enable bit clear, no command launches and `byte_ready` stays low. Command codes 0 and 3 never launch anything.
- R11: While SCL is released but read low (slave stretching), the engine holds its step, so the operation takes more ticks but sends the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Quarter-bit-period step pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write value {rs, cmd[1:0], en} |
| ctl_rdata | output | 4 | Control read value {nak, cmd[1:0], en} |
| byte_valid | input | 1 | Data byte offered |
| byte_data | input | 8 | Data byte to transmit |
| byte_ready | output | 1 | Byte accepted when high together with valid; low while busy, disabled, or during a control write |
| cmd_busy | output | 1 | Operation in progress |
| sess_done | output | 1 | Sticky completion flag |
| done_clr | input | 1 | Clears `sess_done` |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe_n | output | 1 | SCL pull-down enable, active low |
| sda_oe_n | output | 1 | SDA pull-down enable, active low |

## Verification
Two events can land in the same cycle: the completion of an operation, which sets `sess_done`, and a software clear through `done_clr`. The bench holds `done_clr` high for the whole of an operation, so that the clear coincides with the completing edge. At the first falling clock edge after `cmd_busy` drops, it expects `sess_done` to read 1. A separate lone clear pulse must then bring the flag to 0.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_START,
    OP_RESTART,
    OP_STOP,
    OP_BYTE
  } op_e;

  localparam int        CTL_W     = 4;
  localparam int        EN_BIT    = 0;
  localparam int        CMD_LSB   = 1;
  localparam int        RS_BIT    = 3;
  localparam logic [1:0] CMD_IDLE = 2'd0;
  localparam logic [1:0] CMD_GO   = 2'd1;
  localparam logic [1:0] CMD_HALT = 2'd2;
endpackage

// File: rtl/i2c_eng_ctl.sv
module i2c_eng_ctl
  import i2c_eng_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [CTL_W-1:0]    ctl_wdata,
  input  logic                byte_valid,
  input  logic [BYTE_W-1:0]   byte_data,
  input  logic                busy,
  output logic                en,
  output logic [1:0]          cmd,
  output logic                launch,
  output op_e                 launch_op,
  output logic [BYTE_W-1:0]   launch_byte,
  output logic                byte_ready
);
  logic       en_q;
  logic [1:0] cmd_q;
  logic [1:0] wcmd;
  logic       ctl_go;
  logic       byte_take;

  assign wcmd = ctl_wdata[CMD_LSB+1:CMD_LSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cmd_q <= CMD_IDLE;
    end else if (ctl_we && !busy) begin
      en_q  <= ctl_wdata[EN_BIT];
      cmd_q <= wcmd;
    end
  end

  always_comb begin
    ctl_go     = ctl_we && !busy && ctl_wdata[EN_BIT] &&
                 ((wcmd == CMD_GO) || (wcmd == CMD_HALT));
    byte_ready = en_q && !busy && !ctl_we;
    byte_take  = byte_valid && byte_ready;
    launch     = ctl_go || byte_take;
    if (ctl_go) begin
      if (wcmd == CMD_HALT)          launch_op = OP_STOP;
      else if (ctl_wdata[RS_BIT])    launch_op = OP_RESTART;
      else                           launch_op = OP_START;
    end else if (byte_take) begin
      launch_op = OP_BYTE;
    end else begin
      launch_op = OP_NONE;
    end
  end

  assign launch_byte = byte_data;
  assign en          = en_q;
  assign cmd         = cmd_q;

  // R8
  no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/i2c_eng_seq.sv
module i2c_eng_seq
  import i2c_eng_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               launch,
  input  op_e                launch_op,
  input  logic [BYTE_W-1:0]  launch_byte,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               busy,
  output logic               finish,
  output logic               finish_byte,
  output logic               rx_nak,
  output logic               scl_oe_n,
  output logic               sda_oe_n
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [1:0] HIGH_STEP = 2'd2;

  op_e               op_q;
  logic [1:0]        step_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              busy_q, own_q, scl_low_q, sda_low_q, nak_q;
  logic              adv, last;

  always_comb begin
    adv = busy_q && bit_tick && ((step_q != HIGH_STEP) || scl_in);
    case (op_q)
      OP_STOP: last = (step_q == 2'd2);
      OP_BYTE: last = (step_q == 2'd3) && (bit_q == ACK_SLOT);
      default: last = (step_q == 2'd3);
    endcase
  end

  assign finish      = adv && last;
  assign finish_byte = finish && (op_q == OP_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_NONE;
      step_q    <= 2'd0;
      bit_q     <= '0;
      sh_q      <= '0;
      busy_q    <= 1'b0;
      own_q     <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      nak_q     <= 1'b0;
    end else if (launch) begin
      busy_q <= 1'b1;
      op_q   <= launch_op;
      step_q <= (launch_op == OP_START) ? HIGH_STEP : 2'd0;
      bit_q  <= '0;
      sh_q   <= launch_byte;
    end else if (adv) begin
      step_q <= step_q + 2'd1;
      if (last) busy_q <= 1'b0;
      case (op_q)
        OP_START, OP_RESTART: begin
          case (step_q)
            2'd0: sda_low_q <= 1'b0;
            2'd1: scl_low_q <= 1'b0;
            2'd2: sda_low_q <= 1'b1;
            default: begin
              scl_low_q <= 1'b1;
              own_q     <= 1'b1;
            end
          endcase
        end
        OP_STOP: begin
          case (step_q)
            2'd0: sda_low_q <= 1'b1;
            2'd1: scl_low_q <= 1'b0;
            default: begin
              sda_low_q <= 1'b0;
              own_q     <= 1'b0;
            end
          endcase
        end
        OP_BYTE: begin
          case (step_q)
            2'd0: sda_low_q <= (bit_q == ACK_SLOT) ? 1'b0 : ~sh_q[BYTE_W-1];
            2'd1: scl_low_q <= 1'b0;
            2'd2: if (bit_q == ACK_SLOT) nak_q <= sda_in;
            default: begin
              scl_low_q <= 1'b1;
              if (bit_q != ACK_SLOT) begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  assign busy     = busy_q;
  assign rx_nak   = nak_q;
  assign scl_oe_n = ~scl_low_q;
  assign sda_oe_n = ~sda_low_q;

  // R6
  sda_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe_n && $past(scl_oe_n) && (sda_oe_n != $past(sda_oe_n))) |-> (op_q != OP_BYTE));

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !own_q) |-> (scl_oe_n && sda_oe_n));
endmodule

// File: rtl/i2c_eng_stat.sv
module i2c_eng_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic finish,
  input  logic finish_byte,
  input  logic rx_nak,
  input  logic done_clr,
  output logic sess_done,
  output logic ack_flag
);
  logic done_q, ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (finish)        done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (finish_byte)   ack_q  <= rx_nak;
    end
  end

  assign sess_done = done_q;
  assign ack_flag  = ack_q;

  // R9
  done_on_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sess_done);

  // R7
  ack_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish_byte |=> (ack_flag == $past(rx_nak)));
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_eng_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  output logic [3:0]        ctl_rdata,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              cmd_busy,
  output logic              sess_done,
  input  logic              done_clr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe_n,
  output logic              sda_oe_n
);
  logic              en, launch, finish, finish_byte, rx_nak, ack_flag, busy;
  logic [1:0]        cmd;
  op_e               launch_op;
  logic [BYTE_W-1:0] launch_byte;

  i2c_eng_ctl #(.BYTE_W(BYTE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .byte_valid(byte_valid), .byte_data(byte_data), .busy(busy),
    .en(en), .cmd(cmd), .launch(launch), .launch_op(launch_op),
    .launch_byte(launch_byte), .byte_ready(byte_ready)
  );

  i2c_eng_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .launch(launch),
    .launch_op(launch_op), .launch_byte(launch_byte), .scl_in(scl_in),
    .sda_in(sda_in), .busy(busy), .finish(finish), .finish_byte(finish_byte),
    .rx_nak(rx_nak), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n)
  );

  i2c_eng_stat u_stat (
    .clk(clk), .rst_n(rst_n), .busy(busy), .finish(finish),
    .finish_byte(finish_byte), .rx_nak(rx_nak), .done_clr(done_clr),
    .sess_done(sess_done), .ack_flag(ack_flag)
  );

  assign cmd_busy  = busy;
  assign ctl_rdata = {ack_flag, cmd, en};
endmodule

// File: tb/i2c_cmd_engine_tb_top.sv
module i2c_cmd_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic [3:0] ctl_rdata;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_ready, cmd_busy, sess_done;
  logic done_clr = 1'b0;
  logic scl_oe_n, sda_oe_n;
  logic slave_drv = 1'b0;
  logic stretch = 1'b0;
  logic nak_resp = 1'b0;
  logic scl_line, sda_line;

  int n_chk = 0;
  int n_bad = 0;
  int tick_cnt = 0;
  int start_cnt = 0;
  int stop_cnt = 0;
  int bitc = -1;
  int cyc = 0;
  logic [7:0] sh = '0;
  logic [7:0] rx_byte = '0;

  always #2.5 clk = ~clk;

  assign scl_line = scl_oe_n & ~stretch;
  assign sda_line = sda_oe_n & ~slave_drv;

  i2c_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .cmd_busy(cmd_busy),
    .sess_done(sess_done), .done_clr(done_clr), .scl_in(scl_line),
    .sda_in(sda_line), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n)
  );

  // quarter-bit ticks every 4 clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    bit_tick <= (tdiv == 0);
  end

  always @(posedge clk) if (bit_tick && cmd_busy) tick_cnt++;

  // bus slave model
  always @(negedge sda_line) if (scl_line) begin start_cnt++; bitc = -1; sh = '0; end
  always @(posedge sda_line) if (scl_line) stop_cnt++;
  always @(posedge scl_line) if (bitc >= 0 && bitc < 8) sh = {sh[6:0], sda_line};
  always @(negedge scl_line) begin
    bitc++;
    if (bitc == 8) begin rx_byte = sh; slave_drv = !nak_resp; end
    else if (bitc == 9) begin slave_drv = 1'b0; bitc = 0; end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [3:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (cmd_busy);
  endtask

  task automatic do_cmd(input logic rs, input logic [1:0] code, output int ticks);
    int t0;
    t0 = tick_cnt;
    ctl_write({rs, code, 1'b1});
    wait_idle();
    ticks = tick_cnt - t0;
    ctl_write(4'b0001);
  endtask

  task automatic do_byte(input logic [7:0] b, output int ticks);
    int t0;
    t0 = tick_cnt;
    @(negedge clk);
    while (!byte_ready) @(negedge clk);
    byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
    wait_idle();
    ticks = tick_cnt - t0;
  endtask

  // {nak response, byte}
  localparam logic [8:0] VEC [5] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h100, 9'h081};

  initial begin
    int tk, s0, p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 scl", scl_oe_n, 1); check("R1 sda", sda_oe_n, 1);
    check("R1 busy", cmd_busy, 0); check("R1 done", sess_done, 0);
    check("R1 ready", byte_ready, 0); check("R1 rdata", ctl_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 disabled: command ignored
    ctl_write(4'b0010);
    repeat (12) @(negedge clk);
    check("R10 busy", cmd_busy, 0); check("R10 ready", byte_ready, 0);
    check("R10 start", start_cnt, 0); check("R2 rdata", ctl_rdata, 4'b0010);
    ctl_write(4'b0111);
    repeat (12) @(negedge clk);
    check("R10 code3", cmd_busy, 0); check("R10 sda", sda_oe_n, 1);
    ctl_write(4'b0001);
    check("R2 rdata en", ctl_rdata, 4'b0001);

    foreach (VEC[i]) begin
      nak_resp = VEC[i][8];
      s0 = start_cnt; p0 = stop_cnt;
      do_cmd(1'b0, 2'd1, tk);
      check("R3 ticks", tk, 2); check("R3 start", start_cnt, s0 + 1);
      check("R3 scl low", scl_oe_n, 0);
      do_byte(VEC[i][7:0], tk);
      check("R6 data", rx_byte, VEC[i][7:0]); check("R6 ticks", tk, 36);
      check("R7 ack", ctl_rdata[3], VEC[i][8]); check("R9 done", sess_done, 1);
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
      check("R9 clr", sess_done, 0);
      do_cmd(1'b0, 2'd2, tk);
      check("R5 ticks", tk, 3); check("R5 stop", stop_cnt, p0 + 1);
      check("R5 scl", scl_oe_n, 1); check("R5 sda", sda_oe_n, 1);
    end
    check("R2 nak rdata", ctl_rdata, 4'b0001);

    // R4 repeated start, R8 busy behaviour, R2 nak readback
    nak_resp = 1'b1;
    do_cmd(1'b0, 2'd1, tk);
    fork
      do_byte(8'h5A, tk);
      begin
        repeat (20) @(negedge clk);
        check("R8 busy", cmd_busy, 1); check("R8 ready", byte_ready, 0);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = 4'b0101;
        @(negedge clk); ctl_we = 1'b0;
        check("R8 ignored", ctl_rdata[2:0], 3'b001);
      end
    join
    check("R2 nak", ctl_rdata, 4'b1001);
    s0 = start_cnt;
    do_cmd(1'b1, 2'd1, tk);
    check("R4 ticks", tk, 4); check("R4 start", start_cnt, s0 + 1);
    check("R4 held", scl_oe_n, 0);

    // R9 set wins over simultaneous clear
    nak_resp = 1'b0;
    done_clr = 1'b1;
    do_byte(8'hC3, tk);
    check("R9 set wins", sess_done, 1);
    done_clr = 1'b0;
    @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    check("R9 lone clr", sess_done, 0);
    check("R7 ack0", ctl_rdata[3], 0);

    // R11 clock stretching
    fork
      do_byte(8'h96, tk);
      begin
        repeat (3) @(negedge clk);
        stretch = 1'b1; repeat (40) @(negedge clk); stretch = 1'b0;
      end
    join
    check("R11 data", rx_byte, 8'h96);
    check("R11 longer", int'(tk > 36), 1);
    do_cmd(1'b0, 2'd2, tk);
    check("R5 final", sda_oe_n & scl_oe_n, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule